// File: doc/BRIEF.md
# Conversion and Clear-Window Sequencer

This block times one event of a gated charge digitizer. A gate strobe opens an event. Once the gate ends, the block holds the unit busy for the conversion time. That time is 12 µs at 13-bit resolution and 9 µs at 12-bit resolution. The block also runs a programmable fast-clear window, which opens when the gate ends. A fast clear that lands inside the window discards the event and frees the unit at once. If no clear comes, the block ends the event and gives a one-cycle commit pulse to the event buffer logic.

All durations are counted in cycles of the reference clock, with `CYC_PER_US` cycles per microsecond. The window setting gives `(fcw_i + 1) * 2` µs, so it covers 2 to 32 µs in 2 µs steps. A window no longer than the conversion costs no time. A longer window moves the end of the event out to its own end. The block samples both settings when it accepts a gate. It has no data stream, so every pin is a plain level or strobe.

Top module: `cnv_clr_seq`

## Requirements
- R1: After reset, busy_o, commit_o and overrun_o are all 0.
- R2: A rising gate_i sampled while idle is accepted, and busy_o is 1 from the next cycle on.
- R3: Let E0 be the first clock edge after acceptance at which gate_i is sampled low. busy_o stays 1 until the edge E0+END, where END = max(CONV, WIN). CONV is 12*CYC_PER_US cycles when res13_i=1 and 9*CYC_PER_US cycles when res13_i=0.
- R4: The window length is WIN = (fcw_i+1)*2*CYC_PER_US cycles. It covers the edges E0+1 through E0+WIN.
- R5: If WIN <= CONV, the event ends at E0+CONV.
- R6: If WIN > CONV, the event ends at E0+WIN.
- R7: If fclr_i is 1 at an edge inside the window, that edge aborts the event. busy_o falls after that edge and commit_o stays 0.
- R8: A fclr_i that is sampled outside the window has no effect. This covers a clear while the gate is high, a clear at E0 itself, a clear after E0+WIN, and a clear while idle.
- R9: An event that is not aborted gives commit_o=1 for exactly one cycle. That cycle is the first cycle in which busy_o is 0.
- R10: A rising gate_i sampled while busy is ignored and does not change the event timing. It sets overrun_o, which then stays 1 until reset.
- R11: res13_i and fcw_i are sampled at the edge that accepts the gate. Changes to them later in the event have no effect on that event.
- R12: The cycle after an abort or a commit, a new gate is accepted as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_i | input | 1 | Gate strobe, high for the integration period |
| fclr_i | input | 1 | Fast-clear strobe |
| res13_i | input | 1 | Resolution select: 1 gives 13-bit timing, 0 gives 12-bit timing |
| fcw_i | input | FCW_W | Clear-window setting, window = (value+1)*2 µs |
| busy_o | output | 1 | High while the unit cannot take a new gate |
| commit_o | output | 1 | One-cycle pulse when an event is kept |
| overrun_o | output | 1 | Sticky flag: a gate arrived while busy |

## Verification
The assertions assume that gate_i and fclr_i are synchronous to clk. They also assume that no gate is held high across the end of an event, so that a leading edge seen while busy really is a stray gate. The stimulus drives each gate for 1 to 4 cycles. Stray gates are single-cycle pulses placed strictly inside the busy period. Clears are single-cycle pulses placed before, inside or after the window, and res13_i and fcw_i are scrambled on every cycle after acceptance.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_GATE = 2'd1,
    PH_CONV = 2'd2
  } phase_t;
endpackage

// File: rtl/seq_edge.sv
module seq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);
  logic d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
endmodule

// File: rtl/seq_limits.sv
module seq_limits #(
  parameter int CW         = 8,
  parameter int FCW_W      = 4,
  parameter int CYC_PER_US = 4,
  parameter int CONV13_US  = 12,
  parameter int CONV12_US  = 9,
  parameter int STEP_US    = 2
) (
  input  logic             res13_i,
  input  logic [FCW_W-1:0] fcw_i,
  output logic [CW-1:0]    win_o,
  output logic [CW-1:0]    end_o
);
  localparam logic [CW-1:0] STEP_CYC = CW'(STEP_US * CYC_PER_US);
  localparam logic [CW-1:0] C13_CYC  = CW'(CONV13_US * CYC_PER_US);
  localparam logic [CW-1:0] C12_CYC  = CW'(CONV12_US * CYC_PER_US);

  logic [CW-1:0] steps;
  logic [CW-1:0] conv;

  assign steps = CW'(fcw_i) + CW'(1);
  assign win_o = steps * STEP_CYC;
  assign conv  = res13_i ? C13_CYC : C12_CYC;
  assign end_o = (win_o > conv) ? win_o : conv;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_i,
  input  logic          rise_i,
  input  logic          fclr_i,
  input  logic [CW-1:0] win_i,
  input  logic [CW-1:0] end_i,
  output logic          accept_o,
  output phase_t        phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          busy_o,
  output logic          commit_o,
  output logic          overrun_o
);
  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last     = end_i - CW'(1);
  assign accept_o = (phase == PH_IDLE) && rise_i;
  assign busy_o   = (phase != PH_IDLE);
  assign phase_o  = phase;
  assign cnt_o    = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      commit_o  <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      if (rise_i && phase != PH_IDLE) overrun_o <= 1'b1;
      case (phase)
        PH_IDLE: begin
          if (rise_i) phase <= PH_GATE;
        end
        PH_GATE: begin
          if (!gate_i) begin
            phase <= PH_CONV;
            cnt   <= '0;
          end
        end
        PH_CONV: begin
          if (fclr_i && cnt < win_i) begin
            phase <= PH_IDLE;
          end else if (cnt == last) begin
            phase    <= PH_IDLE;
            commit_o <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cnv_clr_seq.sv
module cnv_clr_seq
  import seq_pkg::*;
#(
  parameter int CYC_PER_US = 4,
  parameter int FCW_W      = 4,
  parameter int CONV13_US  = 12,
  parameter int CONV12_US  = 9,
  parameter int STEP_US    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_i,
  input  logic             fclr_i,
  input  logic             res13_i,
  input  logic [FCW_W-1:0] fcw_i,
  output logic             busy_o,
  output logic             commit_o,
  output logic             overrun_o
);
  localparam int WMAX_US = (2 ** FCW_W) * STEP_US;
  localparam int MAX_US  = (CONV13_US > WMAX_US) ? CONV13_US : WMAX_US;
  localparam int CW      = $clog2(MAX_US * CYC_PER_US + 1) + 1;

  logic             rise;
  logic             accept;
  logic             res13_q;
  logic [FCW_W-1:0] fcw_q;
  logic [CW-1:0]    win_c;
  logic [CW-1:0]    end_c;
  logic [CW-1:0]    cnt;
  phase_t           phase;
  logic             in_conv;

  assign in_conv = (phase == PH_CONV);

  seq_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (gate_i),
    .rise_o (rise)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res13_q <= 1'b1;
      fcw_q   <= '0;
    end else if (accept) begin
      res13_q <= res13_i;
      fcw_q   <= fcw_i;
    end
  end

  seq_limits #(
    .CW(CW), .FCW_W(FCW_W), .CYC_PER_US(CYC_PER_US),
    .CONV13_US(CONV13_US), .CONV12_US(CONV12_US), .STEP_US(STEP_US)
  ) u_lim (
    .res13_i (res13_q),
    .fcw_i   (fcw_q),
    .win_o   (win_c),
    .end_o   (end_c)
  );

  seq_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_i    (gate_i),
    .rise_i    (rise),
    .fclr_i    (fclr_i),
    .win_i     (win_c),
    .end_i     (end_c),
    .accept_o  (accept),
    .phase_o   (phase),
    .cnt_o     (cnt),
    .busy_o    (busy_o),
    .commit_o  (commit_o),
    .overrun_o (overrun_o)
  );
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gate_i,
  input logic          fclr_i,
  input logic          busy_o,
  input logic          commit_o,
  input logic          overrun_o,
  input logic          in_conv,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] win_c,
  input logic [CW-1:0] end_c
);
  AST_BUSY_ON_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_i) && !busy_o) |=> busy_o); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_conv |-> (cnt < end_c)); // R3
  AST_CLEAR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_conv && fclr_i && cnt < win_c) |=> (!busy_o && !commit_o)); // R7
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o); // R9
  AST_COMMIT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $fell(busy_o)); // R9
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_i) && busy_o) |=> overrun_o); // R10
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o); // R10
endmodule

bind cnv_clr_seq seq_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_i    (gate_i),
  .fclr_i    (fclr_i),
  .busy_o    (busy_o),
  .commit_o  (commit_o),
  .overrun_o (overrun_o),
  .in_conv   (in_conv),
  .cnt       (cnt),
  .win_c     (win_c),
  .end_c     (end_c)
);

// File: tb/sim_cnv_clr_seq.sv
module sim_cnv_clr_seq;
  localparam int C     = 4;
  localparam int FW    = 4;
  localparam int NOCLR = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_i = 1'b0;
  logic fclr_i = 1'b0;
  logic res13_i = 1'b0;
  logic [FW-1:0] fcw_i = '0;
  logic busy_o, commit_o, overrun_o;

  int nchk = 0;
  int nerr = 0;
  bit ov_exp = 1'b0;

  always #4 clk = ~clk;

  cnv_clr_seq #(.CYC_PER_US(C), .FCW_W(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .fclr_i(fclr_i),
    .res13_i(res13_i), .fcw_i(fcw_i),
    .busy_o(busy_o), .commit_o(commit_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int conv_len(input bit r13);
    return r13 ? 12 * C : 9 * C;
  endfunction

  function automatic int win_len(input int f);
    return (f + 1) * 2 * C;
  endfunction

  function automatic int end_len(input bit r13, input int f);
    return (win_len(f) > conv_len(r13)) ? win_len(f) : conv_len(r13);
  endfunction

  // k: clear driven so that it is sampled at edge E0+k (NOCLR for none)
  task automatic run_event(input bit r13, input int f, input int gw, input int k,
                           input bit want_extra, input int extra_off);
    int  w, e, exp_len, extra, hi, i;
    bit  aborted, done, commit_end, stray;
    string lbl;
    w = win_len(f);
    e = end_len(r13, f);
    aborted = (k >= 1 && k <= w);
    exp_len = aborted ? k : e;
    extra = want_extra ? gw + 1 + (extra_off % exp_len) : -1;
    if (aborted) lbl = "R7";
    else if (k != NOCLR) lbl = "R8";
    else if (w > conv_len(r13)) lbl = "R6/R4";
    else lbl = "R5/R3";
    hi = 0; i = 0; done = 0; commit_end = 0; stray = 0;
    while (!done && i < 1000) begin
      @(negedge clk);
      if (i >= 1) begin
        if (busy_o) begin
          hi++;
          if (commit_o) stray = 1;
        end else begin
          done = 1;
          commit_end = commit_o;
        end
      end
      if (!done) begin
        gate_i  = (i < gw) || (i == extra);
        fclr_i  = (i == gw + k);
        res13_i = (i == 0) ? r13 : 1'($urandom);
        fcw_i   = (i == 0) ? FW'(f) : FW'($urandom);
      end
      i++;
    end
    gate_i = 1'b0;
    fclr_i = 1'b0;
    if (want_extra) ov_exp = 1'b1;
    chk(hi == gw + exp_len, {lbl, " busy length R11 R2"}, hi, gw + exp_len);
    chk(commit_end == !aborted, aborted ? "R7 commit" : "R9 commit", commit_end, !aborted);
    chk(!stray, "R9 commit while busy", stray, 0);
    chk(overrun_o == ov_exp, "R10 overrun", overrun_o, ov_exp);
    @(negedge clk);
    chk(commit_o == 1'b0, "R9 single pulse", commit_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int r13, f, gw, m, w, e, k;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!busy_o && !commit_o && !overrun_o, "R1 reset",
        {busy_o, commit_o, overrun_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    fclr_i = 1'b1;
    @(negedge clk);
    fclr_i = 1'b0;
    chk(!busy_o, "R8 idle clear", busy_o, 0);

    run_event(1, 0, 2, NOCLR, 0, 0);   // R5 13-bit short window
    run_event(0, 0, 1, NOCLR, 0, 0);   // R3 12-bit
    run_event(1, 15, 3, NOCLR, 0, 0);  // R6 longest window
    run_event(0, 4, 2, NOCLR, 0, 0);   // R6 window just above 12-bit conv
    run_event(1, 5, 2, NOCLR, 0, 0);   // R5 window equal to conv
    run_event(1, 3, 2, 1, 0, 0);       // R7 first window edge
    run_event(0, 3, 1, win_len(3), 0, 0);      // R7 last window edge, R12 next
    run_event(0, 3, 2, win_len(3) + 1, 0, 0);  // R8 just past window
    run_event(1, 1, 3, 0, 0, 0);       // R8 clear at E0
    run_event(1, 1, 3, -2, 0, 0);      // R8 clear during gate
    run_event(0, 15, 2, 5, 1, 0);      // R10 stray gate then abort
    run_event(1, 2, 2, NOCLR, 1, 999); // R10 stray gate, timing kept

    for (int n = 0; n < 250; n++) begin
      r13 = $urandom % 2;
      f   = $urandom % 16;
      gw  = 1 + $urandom % 4;
      w   = win_len(f);
      e   = end_len(r13[0], f);
      m   = $urandom % 4;
      k   = NOCLR;
      if (m == 1) k = 1 + $urandom % w;
      else if (m == 2 && e > w) k = w + 1 + $urandom % (e - w);
      else if (m == 3) k = -($urandom % gw);
      run_event(r13[0], f, gw, k, ($urandom % 5) == 0, $urandom % 512);
    end

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy_o && !commit_o && !overrun_o, "R1 R10 second reset",
        {busy_o, commit_o, overrun_o}, 0);
    rst_n = 1'b1;
    ov_exp = 1'b0;
    run_event(0, 7, 1, NOCLR, 0, 0);   // R12 after reset

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule